// File: doc/BRIEF.md
# Chip-Select Region Address Decoder

This block sits at the front of a peripheral bus controller. It takes a 40-bit physical address and claims it if it falls inside a fixed peripheral window. It then picks one of eight programmable regions and drives that region's active-low chip-select line. A simple write port programs each region. The port writes either the region's base address or its size code. An address inside the window that no region covers produces an error strobe instead of a select.

A request is captured on one clock edge. The decode result is then valid during the following cycle. Region 0 leaves reset already mapped as a 4 MB boot region. A static divert input can route region-0 hits away from chip-select 0 and flag them on a separate strobe instead, for an alternate serial boot path.

Top module: `csel_region_decode`

## Requirements
- R1: An address from 0x00_1009_0000 to 0x00_3FFF_FFFF inclusive is claimed (hit or err is 1). Any other address leaves hit, err and div at 0 and every cs_n bit at 1.
- R2: A write with wr_en=1 and wr_field=0 sets the base of region wr_idx to wr_data (bits 39..16 are kept). A write with wr_field=1 sets the size code of region wr_idx to wr_data[4:0].
- R3: At most one cs_n bit is 0 in any cycle. On a hit without divert, the cs_n bit of the winning region is 0.
- R4: A claimed address that matches no enabled region drives err=1 and hit=0, and leaves all cs_n bits at 1.
- R5: After reset, region 0 covers 0x00_1FC0_0000 to 0x00_1FFF_FFFF (base 0x1FC0_0000, size code 7). Regions 1 to 7 have size code 0.
- R6: With boot_divert=1, a hit whose winner is region 0 drives hit=1, div=1, sel_idx=0 and sel_oh=8'h01, and leaves cs_n[0] at 1.
- R7: A size code k from 1 to 24 makes a region 2^(k+15) bytes long. Codes above 24 act as 24, and code 0 disables the region. Base bits below the region size are ignored, so a misaligned base is rounded down.
- R8: When several enabled regions match, the lowest-numbered one wins.
- R9: The outputs reflect the request sampled at the previous rising edge when req_valid was 1. After a cycle with req_valid=0, all outputs are idle (cs_n all 1, hit, err and div 0, sel_oh 0, sel_idx 0).
- R10: On a hit, sel_idx holds the winning region number and sel_oh has exactly that bit set. Otherwise sel_oh is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 40 | Physical address of the request |
| boot_divert | input | 1 | Static option: route region-0 hits to the alternate boot port |
| wr_en | input | 1 | Region register write strobe |
| wr_idx | input | 3 | Region number to write |
| wr_field | input | 1 | 0 = base, 1 = size code |
| wr_data | input | 40 | Write data |
| cs_n | output | 8 | Active-low chip selects, one per region |
| sel_oh | output | 8 | One-hot winning region |
| sel_idx | output | 3 | Winning region number |
| hit | output | 1 | Claimed address matched a region |
| err | output | 1 | Claimed address matched no region |
| div | output | 1 | Region-0 hit diverted to the alternate boot port |

## Verification
A corrupted base or size register shows up one cycle after the next request into that region. The symptoms are a wrong cs_n line, an err where a hit belongs, or a neighbouring region taking the access. Each region is therefore probed at its first and last byte and one byte beyond. A broken priority or mask shows as a wrong sel_idx on overlapping regions during that same result cycle. A stuck request register shows as outputs that fail to go idle the cycle after req_valid drops.

// File: rtl/csel_pkg.sv
package csel_pkg;
    parameter int ADDR_W   = 40;
    parameter int N_REG    = 8;
    parameter int IDX_W    = $clog2(N_REG);
    parameter int GRAN_LOG = 16;
    parameter int PAGE_W   = ADDR_W - GRAN_LOG;
    parameter int SZ_W     = 5;
    parameter int SZ_MAX   = PAGE_W;
    parameter int SZ_BIAS  = GRAN_LOG - 1;

    parameter logic [ADDR_W-1:0] WIN_LO    = 40'h00_1009_0000;
    parameter logic [ADDR_W-1:0] WIN_HI    = 40'h00_3FFF_FFFF;
    parameter logic [ADDR_W-1:0] BOOT_BASE = 40'h00_1FC0_0000;
    parameter logic [SZ_W-1:0]   BOOT_SZ   = 5'd7;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [SZ_W-1:0]   sz;
    } region_t;

    typedef struct packed {
        logic             hit;
        logic             err;
        logic             div;
        logic [N_REG-1:0] oh;
        logic [IDX_W-1:0] idx;
    } dec_t;

    function automatic logic in_window(input logic [ADDR_W-1:0] a);
        return (a >= WIN_LO) && (a <= WIN_HI);
    endfunction

    function automatic logic [PAGE_W-1:0] page_mask(input logic [SZ_W-1:0] k);
        logic [PAGE_W-1:0] m;
        int keff;
        keff = (int'(k) > SZ_MAX) ? SZ_MAX : int'(k);
        for (int j = 0; j < PAGE_W; j++) m[j] = (j >= keff - 1);
        return m;
    endfunction
endpackage

// File: rtl/csel_region_bank.sv
module csel_region_bank
    import csel_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RST_BASE = BOOT_BASE,
    parameter logic [SZ_W-1:0]   RST_SZ   = BOOT_SZ
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic                      wr_field,
    input  logic [ADDR_W-1:0]         wr_data,
    output region_t [N_REG-1:0]       regs
);
    logic unused_wr_bits;
    assign unused_wr_bits = ^wr_data[GRAN_LOG-1:SZ_W];

    for (genvar i = 0; i < N_REG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                if (i == 0) begin
                    regs[i].page <= RST_BASE[ADDR_W-1:GRAN_LOG];
                    regs[i].sz   <= RST_SZ;
                end else begin
                    regs[i].page <= '0;
                    regs[i].sz   <= '0;
                end
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                if (wr_field) regs[i].sz   <= wr_data[SZ_W-1:0];
                else          regs[i].page <= wr_data[ADDR_W-1:GRAN_LOG];
            end
        end
    end
endmodule

// File: rtl/csel_region_match.sv
module csel_region_match
    import csel_pkg::*;
(
    input  logic [PAGE_W-1:0]   addr_page,
    input  region_t [N_REG-1:0] regs,
    output logic [N_REG-1:0]    match
);
    for (genvar i = 0; i < N_REG; i++) begin : g_cmp
        logic [PAGE_W-1:0] keep;
        assign keep     = page_mask(regs[i].sz);
        assign match[i] = (regs[i].sz != '0) &&
                          (((addr_page ^ regs[i].page) & keep) == '0);
    end
endmodule

// File: rtl/csel_prio_pick.sv
module csel_prio_pick
    import csel_pkg::*;
(
    input  logic [N_REG-1:0] match,
    output logic             any,
    output logic [IDX_W-1:0] idx,
    output logic [N_REG-1:0] oh
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        oh  = '0;
        for (int i = N_REG - 1; i >= 0; i--) begin
            if (match[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
                oh  = N_REG'(1) << i;
            end
        end
    end
endmodule

// File: rtl/csel_region_decode.sv
module csel_region_decode
    import csel_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              boot_divert,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_field,
    input  logic [ADDR_W-1:0] wr_data,
    output logic [N_REG-1:0]  cs_n,
    output logic [N_REG-1:0]  sel_oh,
    output logic [IDX_W-1:0]  sel_idx,
    output logic              hit,
    output logic              err,
    output logic              div
);
    logic              q_valid;
    logic [ADDR_W-1:0] q_addr;
    region_t [N_REG-1:0] regs;
    logic [N_REG-1:0]  match;
    logic              any;
    logic [IDX_W-1:0]  win_idx;
    logic [N_REG-1:0]  win_oh;
    dec_t              dec;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid <= 1'b0;
            q_addr  <= '0;
        end else begin
            q_valid <= req_valid;
            if (req_valid) q_addr <= req_addr;
        end
    end

    csel_region_bank u_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_field(wr_field), .wr_data(wr_data), .regs(regs)
    );

    csel_region_match u_match (
        .addr_page(q_addr[ADDR_W-1:GRAN_LOG]), .regs(regs), .match(match)
    );

    csel_prio_pick u_pick (
        .match(match), .any(any), .idx(win_idx), .oh(win_oh)
    );

    always_comb begin
        dec = '0;
        if (q_valid && in_window(q_addr)) begin
            if (any) begin
                dec.hit = 1'b1;
                dec.idx = win_idx;
                dec.oh  = win_oh;
                dec.div = boot_divert && (win_idx == '0);
            end else begin
                dec.err = 1'b1;
            end
        end
    end

    assign hit     = dec.hit;
    assign err     = dec.err;
    assign div     = dec.div;
    assign sel_oh  = dec.oh;
    assign sel_idx = dec.idx;
    assign cs_n    = dec.div ? '1 : ~dec.oh;
endmodule

module csel_region_decode_chk
    import csel_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              boot_divert,
    input logic [N_REG-1:0]  cs_n,
    input logic [N_REG-1:0]  sel_oh,
    input logic [IDX_W-1:0]  sel_idx,
    input logic              hit,
    input logic              err,
    input logic              div
);
    p_one_cs_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n));

    p_err_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        err |-> (!hit && (&cs_n) && sel_oh == '0));

    p_outside_r1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !in_window(req_addr)) |=> (!hit && !err && !div && (&cs_n)));

    p_claimed_r1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && in_window(req_addr)) |=> (hit || err));

    p_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!hit && !err && !div && (&cs_n) && sel_oh == '0));

    p_divert_r6: assert property (@(posedge clk) disable iff (rst)
        div |-> (hit && cs_n[0] && sel_idx == '0 && boot_divert));

    p_sel_match_r10: assert property (@(posedge clk) disable iff (rst)
        (hit && !div) |-> (cs_n == ~sel_oh && $countones(sel_oh) == 1));
endmodule

bind csel_region_decode csel_region_decode_chk u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .boot_divert(boot_divert), .cs_n(cs_n), .sel_oh(sel_oh),
    .sel_idx(sel_idx), .hit(hit), .err(err), .div(div)
);

// File: tb/csel_region_decode_tb.sv
module csel_region_decode_tb;
    logic        clk = 0;
    logic        rst = 1;
    logic        req_valid = 0;
    logic [39:0] req_addr = '0;
    logic        boot_divert = 0;
    logic        wr_en = 0;
    logic [2:0]  wr_idx = '0;
    logic        wr_field = 0;
    logic [39:0] wr_data = '0;
    logic [7:0]  cs_n, sel_oh;
    logic [2:0]  sel_idx;
    logic        hit, err, div;

    always #10 clk = ~clk;

    csel_region_decode u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .boot_divert(boot_divert), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_field(wr_field), .wr_data(wr_data), .cs_n(cs_n), .sel_oh(sel_oh),
        .sel_idx(sel_idx), .hit(hit), .err(err), .div(div)
    );

    typedef struct {
        logic [7:0] cs_n;
        logic [7:0] oh;
        logic [2:0] idx;
        logic       hit, err, div;
        string      tag;
    } exp_t;

    exp_t        exp_q[$];
    int          total = 0, bad = 0;
    logic [39:0] m_base [8];
    logic [4:0]  m_sz   [8];
    bit          done = 0;

    function automatic exp_t model(input logic v, input logic [39:0] a, input string tag);
        exp_t e;
        e.cs_n = 8'hFF; e.oh = 0; e.idx = 0; e.hit = 0; e.err = 0; e.div = 0; e.tag = tag;
        if (v && a >= 40'h00_1009_0000 && a <= 40'h00_3FFF_FFFF) begin
            e.err = 1;
            for (int i = 7; i >= 0; i--) begin
                int k;
                int sh;
                k = (m_sz[i] > 24) ? 24 : int'(m_sz[i]);
                sh = k + 15;
                if (m_sz[i] != 0 && (a >> sh) == (m_base[i] >> sh)) begin
                    e.hit = 1; e.err = 0; e.idx = 3'(i); e.oh = 8'(1) << i;
                end
            end
            if (e.hit) begin
                e.div  = boot_divert && (e.idx == 0);
                e.cs_n = e.div ? 8'hFF : ~e.oh;
            end
        end
        return e;
    endfunction

    task automatic check(input bit ok, input string msg);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s", msg);
        end
    endtask

    // driver: a request (or idle) cycle
    task automatic access(input logic v, input logic [39:0] a, input string tag);
        @(negedge clk);
        wr_en = 0; req_valid = v; req_addr = a;
        exp_q.push_back(model(v, a, tag));
    endtask

    task automatic wreg(input int r, input logic f, input logic [39:0] d);
        @(negedge clk);
        req_valid = 0; wr_en = 1; wr_idx = 3'(r); wr_field = f; wr_data = d;
        exp_q.push_back(model(0, 0, "R2 write cycle idle"));
        if (f) m_sz[r] = d[4:0];
        else   m_base[r] = {d[39:16], 16'h0};
    endtask

    // monitor
    always @(posedge clk) begin
        #5;
        if (!rst && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(cs_n == e.cs_n && sel_oh == e.oh && sel_idx == e.idx &&
                  hit == e.hit && err == e.err && div == e.div,
                  $sformatf("%s: got cs_n=%h oh=%h idx=%0d hit=%b err=%b div=%b exp cs_n=%h oh=%h idx=%0d hit=%b err=%b div=%b",
                            e.tag, cs_n, sel_oh, sel_idx, hit, err, div,
                            e.cs_n, e.oh, e.idx, e.hit, e.err, e.div));
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        m_base[0] = 40'h00_1FC0_0000; m_sz[0] = 7;
        for (int i = 1; i < 8; i++) begin m_base[i] = 0; m_sz[i] = 0; end
        repeat (3) @(posedge clk);
        #5;
        check(cs_n == 8'hFF && !hit && !err && !div && sel_oh == 0,
              $sformatf("R9 reset idle: got cs_n=%h hit=%b err=%b exp cs_n=ff hit=0 err=0", cs_n, hit, err));
        @(negedge clk); rst = 0;

        // R5 boot mapping
        access(1, 40'h00_1FC0_0000, "R5 boot first byte");
        access(1, 40'h00_1FFF_FFFF, "R5 boot last byte");
        access(1, 40'h00_1FBF_FFFF, "R5/R4 below boot");
        access(1, 40'h00_2000_0000, "R5/R4 above boot");
        access(0, 40'h00_1FC0_0000, "R9 idle after request");
        // R1 window edges
        access(1, 40'h00_1008_FFFF, "R1 below window");
        access(1, 40'h00_1009_0000, "R1 window low edge");
        access(1, 40'h00_3FFF_FFFF, "R1 window high edge");
        access(1, 40'h00_4000_0000, "R1 above window");
        access(1, 40'h40_0000_0000, "R1 high address bits");
        // R2/R7 64 KB region
        wreg(3, 0, 40'h00_2000_0000);
        wreg(3, 1, 40'd1);
        access(1, 40'h00_2000_0000, "R7 64KB first");
        access(1, 40'h00_2000_FFFF, "R7 64KB last");
        access(1, 40'h00_2001_0000, "R7/R4 64KB beyond");
        // R8 overlap
        wreg(5, 0, 40'h00_2000_0000);
        wreg(5, 1, 40'd5);
        access(1, 40'h00_2000_1000, "R8 overlap lowest wins");
        access(1, 40'h00_2008_0000, "R8 larger region beyond small");
        access(1, 40'h00_2010_0000, "R7 1MB beyond");
        // R7 misaligned base
        wreg(1, 0, 40'h00_3012_3456);
        wreg(1, 1, 40'd9);
        access(1, 40'h00_3000_0000, "R7 misaligned base rounded");
        access(1, 40'h00_30FF_FFFF, "R7 16MB last");
        access(1, 40'h00_3100_0000, "R7 16MB beyond");
        // region outside window not claimed
        wreg(4, 0, 40'h00_4000_0000);
        wreg(4, 1, 40'd1);
        access(1, 40'h00_4000_0000, "R1 region outside window unclaimed");
        // R6 divert
        @(negedge clk); boot_divert = 1;
        access(1, 40'h00_1FC0_0010, "R6 divert region0");
        access(1, 40'h00_2000_0004, "R6 divert other region untouched");
        access(0, 0, "R9 idle");
        @(negedge clk); boot_divert = 0;
        access(1, 40'h00_1FC0_0010, "R3 boot cs after divert off");
        // R7 disable region0
        wreg(0, 1, 40'd0);
        access(1, 40'h00_1FC0_0000, "R7 size zero disables");
        wreg(0, 1, 40'd7);
        access(1, 40'h00_1FD0_0000, "R2 region0 re-enabled");
        // R7 clamp: huge code on region 7 covers whole window
        wreg(7, 0, 40'h00_0000_0000);
        wreg(7, 1, 40'd31);
        access(1, 40'h00_2100_0000, "R7 clamped code covers window");
        access(1, 40'h00_2000_0000, "R8 lower region beats region 7");
        access(1, 40'h00_1FC0_0000, "R10 region0 index");
        access(0, 0, "R9 final idle");
        repeat (3) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule